// File: doc/BRIEF.md
# Write-Once Dual-Source Watchdog

This block is a watchdog counter for a system that has two slow timing sources: an on-chip ring oscillator and an external crystal. Each source reaches the block as a one-cycle enable pulse in the main clock domain. Software sets the block up through a single 8-bit mode register on a small register bus. That register holds a two-bit source field and a three-bit period field. The register can be read at any time, but only the first write after reset is accepted. Every later write is dropped until the next reset, so a program that has gone astray cannot turn the watchdog off or slow it down.

The counter steps once per pulse of the chosen source. When it reaches the chosen period, the block raises a reset request for one cycle and starts over from zero. Software services the watchdog with a restart strobe. A board-level strap can pin the block to the ring-oscillator source, and while the strap is high the stop encoding has no effect.

Top module: `guard_timer`

## Requirements
- R1: After reset, a read of the mode register (bus address 0xFF98) returns 0x67: source field 00 (ring oscillator) and period field 111.
- R2: A read at any address other than 0xFF98 returns 0x00.
- R3: The first write to 0xFF98 after reset loads bits 4:0. Later writes change neither the register nor the running count until the next reset.
- R4: Bits 7:5 of the mode register always read as 011, whatever value was written.
- R5: With source field 00, the request follows the 2^(11+p)-th ring pulse, where p is the period field (bits 2:0). Crystal pulses have no effect in this mode.
- R6: With source field 01, the request follows the 2^(13+p)-th crystal pulse. Ring pulses have no effect in this mode.
- R7: With source field 10 or 11 and the strap low, the watchdog is stopped: its count stays at zero and no request is raised.
- R8: While the strap input is high, the block counts ring pulses with the ring period law for every value of the source field.
- R9: The request is high for exactly one cycle, in the cycle after the edge that samples the terminal pulse. The count then restarts from zero, so the next request comes after a full period.
- R10: A restart strobe clears the count. If it coincides with the terminal pulse, the restart wins and no request is raised.
- R11: An accepted write that changes the source or period field clears the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Register bus address |
| bus_wr | input | 1 | Register bus write strobe |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Register bus read data, combinational from bus_addr |
| ring_tick | input | 1 | One-cycle enable pulse from the ring-oscillator source |
| xtal_tick | input | 1 | One-cycle enable pulse from the crystal source |
| ring_force | input | 1 | Strap: when high, forces the ring-oscillator source |
| kick | input | 1 | Restart strobe |
| wdt_rst_req | output | 1 | One-cycle reset request |

## Verification
The restart strobe and the terminal pulse can land on the same edge. The bench provokes this by delivering one pulse fewer than the period and then driving the last pulse and the strobe together in one cycle. The check passes only if no request follows that cycle and the next request comes a full period later. A second collision, between a rejected late write and an active count, is judged by the number of pulses that remain before the request.

// File: rtl/guard_pkg.sv
package guard_pkg;

    localparam int REG_W  = 8;
    localparam int CSEL_W = 2;
    localparam int OSEL_W = 3;

    // Upper register bits that are wired to a constant
    localparam logic [2:0] HI_BITS = 3'b011;

    typedef enum logic [1:0] {
        SRC_RING = 2'b00,
        SRC_XTAL = 2'b01,
        SRC_STOP = 2'b10
    } src_e;

    typedef struct packed {
        logic [CSEL_W-1:0] clk_sel;
        logic [OSEL_W-1:0] ovf_sel;
    } mode_t;

    localparam mode_t MODE_RST = '{clk_sel: 2'b00, ovf_sel: 3'b111};

    // The strap overrides the programmed source; the upper select bit means stop
    function automatic src_e pick_src(input mode_t m, input logic force_ring);
        if (force_ring)
            return SRC_RING;
        if (m.clk_sel[1])
            return SRC_STOP;
        return m.clk_sel[0] ? SRC_XTAL : SRC_RING;
    endfunction

endpackage

// File: rtl/guard_cfg.sv
module guard_cfg
    import guard_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 16'hFF98
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output mode_t             mode_o,
    output logic              locked_o,
    output logic              change_o,
    output logic [REG_W-1:0]  rdata_o
);

    typedef struct packed {
        mode_t mode;
        logic  locked;
    } cfg_st_t;

    cfg_st_t st_d, st_q;
    logic    hit_d;
    mode_t   new_d;
    logic    chg_d;

    always_comb begin
        st_d          = st_q;
        hit_d         = bus_wr && (bus_addr == CFG_ADDR);
        new_d.clk_sel = bus_wdata[OSEL_W+CSEL_W-1:OSEL_W];
        new_d.ovf_sel = bus_wdata[OSEL_W-1:0];
        chg_d         = 1'b0;
        if (hit_d && !st_q.locked) begin
            st_d.mode   = new_d;
            st_d.locked = 1'b1;
            chg_d       = (new_d != st_q.mode);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode   <= MODE_RST;
            st_q.locked <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o   = st_q.mode;
    assign locked_o = st_q.locked;
    assign change_o = chg_d;
    assign rdata_o  = (bus_addr == CFG_ADDR) ? {HI_BITS, st_q.mode} : '0;

endmodule

// File: rtl/guard_tick_sel.sv
module guard_tick_sel
    import guard_pkg::*;
#(
    parameter int RING_BASE = 11,
    parameter int XTAL_BASE = 13,
    parameter int CNT_W     = 20
) (
    input  mode_t             mode_i,
    input  logic              ring_tick,
    input  logic              xtal_tick,
    input  logic              ring_force,
    output logic              tick_o,
    output logic              stop_o,
    output logic [CNT_W-1:0]  last_o
);

    localparam int SH_W = $clog2(CNT_W + 1);

    src_e            src_d;
    logic [SH_W-1:0] shamt_d;

    always_comb begin
        src_d  = pick_src(mode_i, ring_force);
        tick_o = 1'b0;
        stop_o = 1'b0;
        case (src_d)
            SRC_RING: begin
                tick_o  = ring_tick;
                shamt_d = SH_W'(RING_BASE) + SH_W'(mode_i.ovf_sel);
            end
            SRC_XTAL: begin
                tick_o  = xtal_tick;
                shamt_d = SH_W'(XTAL_BASE) + SH_W'(mode_i.ovf_sel);
            end
            default: begin
                stop_o  = 1'b1;
                shamt_d = SH_W'(RING_BASE);
            end
        endcase
        // terminal value is 2^shamt - 1: low shamt bits set
        last_o = ~({CNT_W{1'b1}} << shamt_d);
    end

endmodule

// File: rtl/guard_count.sv
module guard_count #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             stop_i,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] last_i,
    output logic [CNT_W-1:0] count_o,
    output logic             req_o
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             req;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (stop_i || clear_i) begin
            st_d.count = '0;
        end else if (tick_i) begin
            if (st_q.count == last_i) begin
                st_d.count = '0;
                st_d.req   = 1'b1;
            end else begin
                st_d.count = st_q.count + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;
    assign req_o   = st_q.req;

endmodule

// File: rtl/guard_timer.sv
module guard_timer
    import guard_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CFG_ADDR  = 16'hFF98,
    parameter int                RING_BASE = 11,
    parameter int                XTAL_BASE = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              ring_tick,
    input  logic              xtal_tick,
    input  logic              ring_force,
    input  logic              kick,
    output logic              wdt_rst_req
);

    localparam int TOP_BASE = (XTAL_BASE > RING_BASE) ? XTAL_BASE : RING_BASE;
    localparam int CNT_W    = TOP_BASE + (1 << OSEL_W) - 1;

    mode_t            mode_q;
    logic             cfg_locked;
    logic             cfg_change;
    logic             src_tick;
    logic             src_stop;
    logic [CNT_W-1:0] src_last;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_clear;

    guard_cfg #(
        .ADDR_W   (ADDR_W),
        .CFG_ADDR (CFG_ADDR)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .mode_o    (mode_q),
        .locked_o  (cfg_locked),
        .change_o  (cfg_change),
        .rdata_o   (bus_rdata)
    );

    guard_tick_sel #(
        .RING_BASE (RING_BASE),
        .XTAL_BASE (XTAL_BASE),
        .CNT_W     (CNT_W)
    ) u_sel (
        .mode_i     (mode_q),
        .ring_tick  (ring_tick),
        .xtal_tick  (xtal_tick),
        .ring_force (ring_force),
        .tick_o     (src_tick),
        .stop_o     (src_stop),
        .last_o     (src_last)
    );

    assign cnt_clear = kick || cfg_change;

    guard_count #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (src_tick),
        .stop_i  (src_stop),
        .clear_i (cnt_clear),
        .last_i  (src_last),
        .count_o (cnt_val),
        .req_o   (wdt_rst_req)
    );

endmodule

// File: rtl/guard_chk.sv
module guard_chk #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 16'hFF98,
    parameter int                CNT_W    = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              kick,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_rdata,
    input logic              rst_req,
    input logic              locked,
    input logic [4:0]        mode,
    input logic              stop,
    input logic [CNT_W-1:0]  count
);

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(mode)); // R3

    AST_HI_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == CFG_ADDR) |-> (bus_rdata[7:5] == 3'b011)); // R4

    AST_OFF_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != CFG_ADDR) |-> (bus_rdata == 8'h00)); // R2

    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (count == '0 && !rst_req)); // R7

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R9

    AST_REQ_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (count == '0)); // R9

    AST_KICK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (count == '0 && !rst_req)); // R10

endmodule

bind guard_timer guard_chk #(
    .ADDR_W   (ADDR_W),
    .CFG_ADDR (CFG_ADDR),
    .CNT_W    (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .kick      (kick),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .rst_req   (wdt_rst_req),
    .locked    (cfg_locked),
    .mode      (mode_q),
    .stop      (src_stop),
    .count     (cnt_val)
);

// File: tb/sim_guard_timer.sv
module sim_guard_timer;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] REG_ADDR = 16'hFF98;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = REG_ADDR;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        ring_tick = 1'b0;
    logic        xtal_tick = 1'b0;
    logic        ring_force = 1'b0;
    logic        kick = 1'b0;
    logic        wdt_rst_req;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    guard_timer u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .ring_tick   (ring_tick),
        .xtal_tick   (xtal_tick),
        .ring_force  (ring_force),
        .kick        (kick),
        .wdt_rst_req (wdt_rst_req)
    );

    // first write, second write, expected readback after both
    localparam logic [23:0] VEC [5] = '{
        {8'h00, 8'hFF, 8'h60},
        {8'hFF, 8'h00, 8'h7F},
        {8'h9A, 8'h05, 8'h7A},
        {8'h08, 8'h10, 8'h68},
        {8'hE7, 8'h01, 8'h67}
    };

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n = 1'b0; ring_tick = 1'b0; xtal_tick = 1'b0; kick = 1'b0;
        bus_wr = 1'b0; bus_addr = REG_ADDR; ring_force = strap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        bus_addr = REG_ADDR; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
        bus_addr = REG_ADDR;
    endtask

    // Drives pulses until a request is seen or the cycle budget runs out
    task automatic run(input int cycles, input int rdiv, input int xdiv,
                       output int rn, output int xn, output bit seen);
        seen = 1'b0; rn = 0; xn = 0;
        for (int c = 0; c <= cycles; c++) begin
            @(negedge clk);
            if (wdt_rst_req) seen = 1'b1;
            if (seen || c == cycles) begin
                ring_tick = 1'b0; xtal_tick = 1'b0;
                break;
            end
            ring_tick = (c % rdiv) == 0;
            xtal_tick = (c % xdiv) == 0;
            rn += int'(ring_tick);
            xn += int'(xtal_tick);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int rn, xn;
        bit seen;

        // R1 / R2: reset state
        do_reset(1'b0);
        rd(REG_ADDR, v);   chk("R1 reset readback", v, 8'h67);
        rd(16'h0000, v);   chk("R2 other address", v, 8'h00);
        rd(16'hFF99, v);   chk("R2 neighbour address", v, 8'h00);
        chk("R1 request low after reset", wdt_rst_req, 0);

        // R3 / R4: table of write pairs
        foreach (VEC[i]) begin
            do_reset(1'b0);
            wr(VEC[i][23:16]);
            rd(REG_ADDR, v); chk("R4 readback after first write", v, VEC[i][7:0]);
            wr(VEC[i][15:8]);
            rd(REG_ADDR, v); chk("R3 second write ignored", v, VEC[i][7:0]);
        end

        // R5: ring source, crystal pulses every cycle must not count
        do_reset(1'b0); wr(8'h00);
        run(10000, 2, 1, rn, xn, seen);
        chk("R5 ring code0 seen", seen, 1); chk("R5 ring code0 pulses", rn, 2048);
        // R9: one-cycle pulse, then a full period again
        @(negedge clk); chk("R9 request one cycle", wdt_rst_req, 0);
        run(5000, 1, 1, rn, xn, seen);
        chk("R9 full period after wrap", rn, 2048);
        do_reset(1'b0); wr(8'h01);
        run(10000, 1, 1, rn, xn, seen);
        chk("R5 ring code1 pulses", rn, 4096);
        do_reset(1'b0); wr(8'h02);
        run(10000, 1, 1, rn, xn, seen);
        chk("R5 ring code2 pulses", rn, 8192);

        // R6: crystal source, ring pulses every cycle must not count
        do_reset(1'b0); wr(8'h08);
        run(30000, 1, 3, rn, xn, seen);
        chk("R6 xtal code0 seen", seen, 1); chk("R6 xtal code0 pulses", xn, 8192);
        do_reset(1'b0); wr(8'h09);
        run(20000, 1, 1, rn, xn, seen);
        chk("R6 xtal code1 pulses", xn, 16384);

        // R7: stop encodings
        do_reset(1'b0); wr(8'h10);
        run(5000, 1, 1, rn, xn, seen);
        chk("R7 stop 10 no request", seen, 0);
        do_reset(1'b0); wr(8'h18);
        run(5000, 1, 1, rn, xn, seen);
        chk("R7 stop 11 no request", seen, 0);

        // R8: strap forces ring source
        do_reset(1'b1); wr(8'h18);
        run(10000, 1, 2, rn, xn, seen);
        chk("R8 strap over stop", rn, 2048);
        do_reset(1'b1); wr(8'h08);
        run(10000, 1, 2, rn, xn, seen);
        chk("R8 strap over xtal", rn, 2048);
        do_reset(1'b0);

        // R10: restart coinciding with terminal pulse
        do_reset(1'b0); wr(8'h00);
        run(2047, 1, 1, rn, xn, seen);
        chk("R10 no early request", seen, 0);
        @(negedge clk); ring_tick = 1'b1; kick = 1'b1;
        @(negedge clk); ring_tick = 1'b0; kick = 1'b0;
        chk("R10 restart wins", wdt_rst_req, 0);
        run(5000, 1, 1, rn, xn, seen);
        chk("R10 full period after restart", rn, 2048);

        // R3: late write neither changes the period nor clears the count
        do_reset(1'b0); wr(8'h00);
        run(1000, 1, 1, rn, xn, seen);
        wr(8'h03);
        run(5000, 1, 1, rn, xn, seen);
        chk("R3 late write ignored", rn, 1048);

        // R11: accepted write that changes fields clears the count
        do_reset(1'b0);
        run(1500, 1, 1, rn, xn, seen);
        wr(8'h00);
        run(5000, 1, 1, rn, xn, seen);
        chk("R11 write clears count", rn, 2048);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule